// File: doc/BRIEF.md
# Multi-latency FP issue hazard checker

This block sits in the decode stage of an in-order pipeline that issues at most one instruction per cycle. Each cycle it receives one decoded instruction: a valid bit, an execution-unit class, one FP destination register and two FP source registers. In the same cycle it answers combinationally with either `issue` or `stall`. A stalled instruction is held at the input and presented again on the next cycle.

The execution units have different fixed latencies. Loads take 2 cycles, adds 4, multiplies 7 and divides 24, and each latency is a parameter. The divider is not pipelined. All results share one FP register write port. At issue the block checks three kinds of hazard using only its own state:
- Structural hazards on the divider and on the write port. A busy counter tracks the divider. A shift register reserves write-port cycles, one bit per future cycle.
- RAW hazards. A per-register table counts down the cycles left until each pending write.
- WAW hazards, using the same per-register table.

Register reads all happen at issue, so WAR is never checked. An instruction is considered to write back `L` cycles after it issues. A consumer may issue in that writeback cycle, because the value is forwarded then.

Top module: `fphz_issue_chk`

## Requirements
- R1: After reset the divider is free, no write cycle is reserved and no register is pending. The first valid instruction of any class issues at once, with `issue`=1 and `stall`=0.
- R2: When `in_valid`=0 the outputs are `issue`=0 and `stall`=0. Such an input reserves no write cycle and creates no pending register, whatever its other fields hold.
- R3: Class encoding on `in_unit`: 0 integer, 1 FP load, 2 FP store, 3 FP add, 4 FP multiply, 5 FP divide. An FP add issued in cycle t makes any consumer of its destination stall in cycles t+1 to t+3. The consumer issues in cycle t+4.
- R4: An FP multiply issued in cycle t makes a consumer of its destination stall in cycles t+1 to t+6. This holds through either source field. The consumer issues in cycle t+7.
- R5: A divide issued in cycle t keeps the divider busy. Another divide stalls in cycles t+1 to t+23 and issues in cycle t+24. Non-divide instructions without other hazards issue while the divider is busy.
- R6: An instruction of class load, add, multiply or divide issued in cycle t with latency L writes back in cycle t+L. A second such instruction whose writeback cycle is already reserved stalls, even when the registers differ.
- R7: An instruction that writes register d stalls when an in-flight write to d completes in the same cycle as its own writeback or later. It may issue once the older write completes strictly earlier.
- R8: A store reads only its first source register, which is the store data. It writes no FP register. A pending write on its second source register does not stall it.
- R9: Integer-class instructions read and write no FP register. They never stall on FP state and reserve nothing.
- R10: A load issued in cycle t makes a consumer of its destination stall in cycle t+1. The consumer issues in cycle t+2.
- R11: A stalled instruction changes no state. It creates no pending register and no write-cycle reservation, and a stalled divide does not restart the divider.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoded instruction present |
| in_unit | input | 3 | Execution-unit class (encoding in R3) |
| in_dst | input | 5 | FP destination register |
| in_src_a | input | 5 | First FP source register (store data) |
| in_src_b | input | 5 | Second FP source register |
| issue | output | 1 | Instruction issues this cycle |
| stall | output | 1 | Instruction must be held and retried |

## Verification
The hardest situation to reach from the ports is a write-after-write conflict that no RAW or write-port conflict hides. The bench starts a long divide on a register. It then presents a short add to the same register with unrelated sources. The add must stall for exactly twenty cycles and issue on the first cycle in which the divide's remaining time falls below the add's latency. A dependent read is then presented to show that the newer, later write now owns the register. Write-port collisions are reached in the same way: a multiply is issued first, and a later add and load are timed so that their writeback cycle lands on a reserved slot.

// File: rtl/fphz_pkg.sv
package fphz_pkg;

  typedef enum logic [2:0] {
    U_INT = 3'd0,
    U_LD  = 3'd1,
    U_ST  = 3'd2,
    U_ADD = 3'd3,
    U_MUL = 3'd4,
    U_DIV = 3'd5
  } unit_e;

  function automatic logic writes_fp(unit_e u);
    return (u == U_LD) || (u == U_ADD) || (u == U_MUL) || (u == U_DIV);
  endfunction

  function automatic logic reads_a(unit_e u);
    return (u == U_ST) || (u == U_ADD) || (u == U_MUL) || (u == U_DIV);
  endfunction

  function automatic logic reads_b(unit_e u);
    return (u == U_ADD) || (u == U_MUL) || (u == U_DIV);
  endfunction

  function automatic int unit_lat(unit_e u, int ld, int add, int mul, int dv);
    case (u)
      U_LD:    return ld;
      U_ADD:   return add;
      U_MUL:   return mul;
      U_DIV:   return dv;
      default: return 0;
    endcase
  endfunction

  function automatic int max4(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/fphz_wport.sv
module fphz_wport #(
  parameter int RW = 25,
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] q_lat,
  output logic          slot_taken,
  input  logic          set_en,
  input  logic [LW-1:0] set_lat
);
  logic [RW-1:0] resv;
  logic [RW-1:0] resv_nxt;

  assign slot_taken = resv[q_lat];

  always_comb begin
    resv_nxt = resv;
    if (set_en) resv_nxt = resv | (RW'(1) << set_lat);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) resv <= '0;
    else        resv <= resv_nxt >> 1;
  end

  // R6
  slot_free_on_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> !resv[set_lat]);

  // R6
  slot_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> resv[$past(set_lat) - 1'b1]);
endmodule

// File: rtl/fphz_divbusy.sv
module fphz_divbusy #(
  parameter int BUSY = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int DBW = $clog2(BUSY + 1);
  logic [DBW-1:0] cnt;

  assign busy = (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (start)  cnt <= DBW'(BUSY - 1);
    else if (busy)   cnt <= cnt - 1'b1;
  end

  // R5
  div_start_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/fphz_pendtab.sv
module fphz_pendtab #(
  parameter int NREG = 32,
  parameter int CW   = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(NREG)-1:0] ra,
  input  logic [$clog2(NREG)-1:0] rb,
  input  logic [$clog2(NREG)-1:0] rd,
  output logic [CW-1:0]           rem_a,
  output logic [CW-1:0]           rem_b,
  output logic [CW-1:0]           rem_d,
  input  logic                    set_en,
  input  logic [$clog2(NREG)-1:0] set_reg,
  input  logic [CW-1:0]           set_val
);
  logic [CW-1:0] cnt [NREG];

  assign rem_a = cnt[ra];
  assign rem_b = cnt[rb];
  assign rem_d = cnt[rd];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                                  cnt[g] <= '0;
      else if (set_en && (int'(set_reg) == g))     cnt[g] <= set_val;
      else if (cnt[g] != '0)                       cnt[g] <= cnt[g] - 1'b1;
    end
  end

  // R7
  waw_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> (cnt[set_reg] <= set_val));
endmodule

// File: rtl/fphz_issue_chk.sv
module fphz_issue_chk
  import fphz_pkg::*;
#(
  parameter int NREG     = 32,
  parameter int LAT_LD   = 2,
  parameter int LAT_ADD  = 4,
  parameter int LAT_MUL  = 7,
  parameter int LAT_DIV  = 24,
  parameter int DIV_BUSY = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [2:0]              in_unit,
  input  logic [$clog2(NREG)-1:0] in_dst,
  input  logic [$clog2(NREG)-1:0] in_src_a,
  input  logic [$clog2(NREG)-1:0] in_src_b,
  output logic                    issue,
  output logic                    stall
);
  localparam int MAXL = max4(LAT_LD, LAT_ADD, LAT_MUL, LAT_DIV);
  localparam int RW   = MAXL + 1;
  localparam int CW   = $clog2(RW);

  unit_e         u;
  logic [CW-1:0] lat;
  logic          wr;
  logic [CW-1:0] rem_a, rem_b, rem_d;
  logic          slot_taken, div_busy;
  logic          raw_hit, waw_hit, port_hit, div_hit;
  logic          wr_issue, div_issue;

  assign u   = unit_e'(in_unit);
  assign lat = CW'(unit_lat(u, LAT_LD, LAT_ADD, LAT_MUL, LAT_DIV));
  assign wr  = writes_fp(u);

  assign raw_hit  = (reads_a(u) && rem_a != '0) || (reads_b(u) && rem_b != '0);
  assign waw_hit  = wr && (rem_d >= lat);
  assign port_hit = wr && slot_taken;
  assign div_hit  = (u == U_DIV) && div_busy;

  assign stall     = in_valid && (raw_hit || waw_hit || port_hit || div_hit);
  assign issue     = in_valid && !stall;
  assign wr_issue  = issue && wr;
  assign div_issue = issue && (u == U_DIV);

  fphz_wport #(.RW(RW), .LW(CW)) wport_i (
    .clk(clk), .rst_n(rst_n), .q_lat(lat), .slot_taken(slot_taken),
    .set_en(wr_issue), .set_lat(lat)
  );

  fphz_divbusy #(.BUSY(DIV_BUSY)) divb_i (
    .clk(clk), .rst_n(rst_n), .start(div_issue), .busy(div_busy)
  );

  fphz_pendtab #(.NREG(NREG), .CW(CW)) pend_i (
    .clk(clk), .rst_n(rst_n), .ra(in_src_a), .rb(in_src_b), .rd(in_dst),
    .rem_a(rem_a), .rem_b(rem_b), .rem_d(rem_d),
    .set_en(wr_issue), .set_reg(in_dst), .set_val(lat - 1'b1)
  );

  // R5
  div_busy_after_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_issue |=> div_busy);

  // R3
  dst_pending_after_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_issue |=> (pend_i.cnt[$past(in_dst)] != '0));
endmodule

// File: tb/fphz_issue_chk_tb_top.sv
module fphz_issue_chk_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [2:0] in_unit = 3'd0;
  logic [4:0] in_dst = 5'd0, in_src_a = 5'd0, in_src_b = 5'd0;
  logic       issue, stall;
  int checks = 0;
  int errors = 0;

  localparam logic [2:0] INT = 3'd0, LD = 3'd1, ST = 3'd2, ADD = 3'd3,
                         MUL = 3'd4, DIV = 3'd5;

  always #4 clk = ~clk;

  fphz_issue_chk dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_unit(in_unit),
    .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
    .issue(issue), .stall(stall)
  );

  task automatic step(input logic v, input logic [2:0] un, input logic [4:0] d,
                      input logic [4:0] a, input logic [4:0] b,
                      input logic ei, input logic es, input string req);
    @(negedge clk);
    in_valid = v; in_unit = un; in_dst = d; in_src_a = a; in_src_b = b;
    #1;
    checks++;
    if (issue !== ei || stall !== es) begin
      errors++;
      $display("FAIL %s issue=%0b stall=%0b expected issue=%0b stall=%0b",
               req, issue, stall, ei, es);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, INT, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, "R2 idle");
  endtask

  task automatic t_reset();
    step(1'b0, INT, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, "R1 reset idle");
    step(1'b1, DIV, 5'd1, 5'd2, 5'd3, 1'b1, 1'b0, "R1 first divide");
    idle(40);
  endtask

  task automatic t_raw_add();
    step(1'b1, ADD, 5'd1, 5'd2, 5'd3, 1'b1, 1'b0, "R3 producer");
    for (int i = 0; i < 3; i++)
      step(1'b1, ADD, 5'd10, 5'd1, 5'd4, 1'b0, 1'b1, "R3 consumer stall");
    step(1'b1, ADD, 5'd10, 5'd1, 5'd4, 1'b1, 1'b0, "R3 consumer issue");
    idle(30);
  endtask

  task automatic t_raw_mul();
    step(1'b1, MUL, 5'd2, 5'd0, 5'd0, 1'b1, 1'b0, "R4 producer");
    for (int i = 0; i < 6; i++)
      step(1'b1, ADD, 5'd11, 5'd5, 5'd2, 1'b0, 1'b1, "R4 consumer stall");
    step(1'b1, ADD, 5'd11, 5'd5, 5'd2, 1'b1, 1'b0, "R4 consumer issue");
    idle(30);
  endtask

  task automatic t_load();
    step(1'b1, LD, 5'd3, 5'd0, 5'd0, 1'b1, 1'b0, "R10 load");
    step(1'b1, ADD, 5'd12, 5'd3, 5'd0, 1'b0, 1'b1, "R10 use stall");
    step(1'b1, ADD, 5'd12, 5'd3, 5'd0, 1'b1, 1'b0, "R10 use issue");
    idle(30);
  endtask

  task automatic t_div();
    step(1'b1, DIV, 5'd4, 5'd0, 5'd0, 1'b1, 1'b0, "R5 first divide");
    step(1'b1, ADD, 5'd13, 5'd0, 5'd0, 1'b1, 1'b0, "R5 add while busy");
    for (int i = 0; i < 22; i++)
      step(1'b1, DIV, 5'd5, 5'd0, 5'd0, 1'b0, 1'b1, "R5 divide stall");
    step(1'b1, DIV, 5'd5, 5'd0, 5'd0, 1'b1, 1'b0, "R5 R11 divide issue at t+24");
    idle(60);
  endtask

  task automatic t_port();
    step(1'b1, MUL, 5'd6, 5'd0, 5'd0, 1'b1, 1'b0, "R6 multiply");
    idle(2);
    step(1'b1, ADD, 5'd7, 5'd0, 5'd0, 1'b0, 1'b1, "R6 add slot clash");
    step(1'b1, ADD, 5'd7, 5'd0, 5'd0, 1'b1, 1'b0, "R6 add next slot");
    step(1'b1, LD, 5'd8, 5'd0, 5'd0, 1'b0, 1'b1, "R6 load clash mul");
    step(1'b1, LD, 5'd8, 5'd0, 5'd0, 1'b0, 1'b1, "R6 load clash add");
    step(1'b1, LD, 5'd8, 5'd0, 5'd0, 1'b1, 1'b0, "R6 load free slot");
    idle(30);
  endtask

  task automatic t_waw();
    step(1'b1, DIV, 5'd9, 5'd0, 5'd0, 1'b1, 1'b0, "R7 divide");
    for (int i = 0; i < 20; i++)
      step(1'b1, ADD, 5'd9, 5'd1, 5'd2, 1'b0, 1'b1, "R7 waw stall");
    step(1'b1, ADD, 5'd9, 5'd1, 5'd2, 1'b1, 1'b0, "R7 waw issue");
    step(1'b1, ADD, 5'd14, 5'd9, 5'd0, 1'b0, 1'b1, "R7 newer write owns reg");
    idle(40);
  endtask

  task automatic t_store();
    step(1'b1, ADD, 5'd1, 5'd0, 5'd0, 1'b1, 1'b0, "R8 producer");
    step(1'b1, ST, 5'd0, 5'd0, 5'd1, 1'b1, 1'b0, "R8 store src_b ignored");
    step(1'b1, ST, 5'd0, 5'd1, 5'd0, 1'b0, 1'b1, "R8 store data stall");
    idle(30);
  endtask

  task automatic t_int();
    step(1'b1, MUL, 5'd2, 5'd0, 5'd0, 1'b1, 1'b0, "R9 multiply");
    step(1'b1, INT, 5'd2, 5'd2, 5'd2, 1'b1, 1'b0, "R9 integer issues");
    idle(30);
  endtask

  task automatic t_invalid();
    step(1'b0, MUL, 5'd3, 5'd0, 5'd0, 1'b0, 1'b0, "R2 invalid multiply");
    step(1'b1, ADD, 5'd14, 5'd3, 5'd3, 1'b1, 1'b0, "R2 no pending from invalid");
    step(1'b0, DIV, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, "R2 invalid divide");
    step(1'b1, ADD, 5'd16, 5'd0, 5'd0, 1'b1, 1'b0, "R2 no slot from invalid");
    step(1'b1, DIV, 5'd17, 5'd0, 5'd0, 1'b1, 1'b0, "R2 divider not started");
    idle(60);
  endtask

  task automatic t_nochange();
    step(1'b1, ADD, 5'd1, 5'd0, 5'd0, 1'b1, 1'b0, "R11 producer");
    step(1'b1, ADD, 5'd7, 5'd1, 5'd0, 1'b0, 1'b1, "R11 stalled add");
    step(1'b1, ADD, 5'd8, 5'd7, 5'd0, 1'b1, 1'b0, "R11 no pending from stall");
    step(1'b1, LD, 5'd9, 5'd0, 5'd0, 1'b1, 1'b0, "R11 no slot from stall");
    idle(30);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_raw_add();
    t_raw_mul();
    t_load();
    t_div();
    t_port();
    t_waw();
    t_store();
    t_int();
    t_invalid();
    t_nochange();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule